// File: doc/BRIEF.md
# Triple-Redundant Configuration Register File

This block stores the global configuration of a chip in a small register file that tolerates upsets. It has 32 words of 16 bits. Every bit is held in three independent storage planes, and every read returns the bitwise majority of the three copies. A single upset in one copy therefore never reaches the read port. Any disagreement between the copies of a word raises that word's flag on a 32-bit mismatch vector, which software or a scrubber can watch.

The write strobe arrives as three separate copies. Each storage plane has its own strobe voter and its own address decoder, so a glitch on one strobe copy cannot load a word by itself. A synchronous clear input is driven by an on-chip radiation-burst detector. It zeroes all three planes and wins over a write in the same cycle. Fault-injection inputs can invert one bit of a chosen word in any chosen combination of planes, so the redundancy can be exercised from the ports.

One address selects both the word that is written and the word that is read. Read data and mismatch flags are combinational from the stored state.

Top module: `tmr_cfg_regfile`

## Requirements
- R1: While `burst_clr` is high at a rising clock edge, all three copies of every word are cleared to zero. After that edge, `rd_data` is 0 for every address and `err_flags` is all zero.
- R2: When all three strobes are high at a rising edge, `wr_data` is stored at `addr`. Words at other addresses are unchanged.
- R3: A write also takes place when exactly two of the three strobes `wr_en_a`, `wr_en_b` and `wr_en_c` are high, whichever two they are.
- R4: When at most one strobe is high, no word changes.
- R5: When `burst_clr` and a majority of strobes are high at the same edge, the clear wins and the word reads 0.
- R6: When exactly one bit of `inj_sel` is high at an edge, the bit `inj_bit` of word `inj_word` is inverted in that plane only (bit 0 is plane A, bit 1 is plane B, bit 2 is plane C). `rd_data` is unchanged and `err_flags[inj_word]` goes to 1.
- R7: A majority-strobe write to a word rewrites all three copies, which clears that word's flag.
- R8: If two planes hold an inverted copy of the same bit, `rd_data` shows the inverted value and the word's flag stays high.
- R9: `rd_data` follows `addr` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| burst_clr | input | 1 | Synchronous clear from the burst detector, active high |
| wr_en_a | input | 1 | Write strobe copy A |
| wr_en_b | input | 1 | Write strobe copy B |
| wr_en_c | input | 1 | Write strobe copy C |
| addr | input | 5 | Word address, used for both write and read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Voted data of the addressed word |
| err_flags | output | 32 | Per-word flag, high when the copies of any bit disagree |
| inj_sel | input | 3 | Planes whose copy of the chosen bit is inverted |
| inj_word | input | 5 | Word targeted by fault injection |
| inj_bit | input | 4 | Bit targeted by fault injection |

## Verification
The hardest state to reach from the ports is a word whose copies disagree. In normal use the three copies are always written together, so a disagreement cannot arise. The stimulus uses the injection inputs to invert one copy, and then a second copy of the same bit. This shows that one corrupted copy is masked and flagged, that two corrupted copies outvote the good one, and that a majority rewrite heals the word. Strobe patterns with only two copies high, and with a single copy high, stand in for a glitch on one strobe line.

// File: rtl/tmr_cfg_pkg.sv
package tmr_cfg_pkg;
  localparam int NCOPY = 3;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic differ3(input logic a, input logic b, input logic c);
    return (a ^ b) | (a ^ c);
  endfunction
endpackage

// File: rtl/tmr_plane.sv
module tmr_plane #(
  parameter int WORDS = 32,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(WORDS),
  localparam int BW = $clog2(WIDTH)
) (
  input  logic                         clk,
  input  logic                         clr,
  input  logic [2:0]                   strobes,
  input  logic [AW-1:0]                addr,
  input  logic [WIDTH-1:0]             wdata,
  input  logic                         flip_en,
  input  logic [AW-1:0]                flip_word,
  input  logic [BW-1:0]                flip_bit,
  output logic [WORDS-1:0][WIDTH-1:0]  store_q
);
  import tmr_cfg_pkg::*;

  // each plane owns its strobe voter and decoder
  logic plane_we;
  assign plane_we = maj3(strobes[0], strobes[1], strobes[2]);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic sel_wr, sel_flip;
    assign sel_wr   = plane_we && (addr == AW'(w));
    assign sel_flip = flip_en && (flip_word == AW'(w));
    always_ff @(posedge clk) begin
      if (clr)
        store_q[w] <= '0;
      else if (sel_wr)
        store_q[w] <= wdata;
      else if (sel_flip)
        store_q[w] <= store_q[w] ^ (WIDTH'(1) << flip_bit);
    end
  end
endmodule

// File: rtl/tmr_word_vote.sv
module tmr_word_vote #(
  parameter int WORDS = 32,
  parameter int WIDTH = 16
) (
  input  logic [WORDS-1:0][WIDTH-1:0] copy_a,
  input  logic [WORDS-1:0][WIDTH-1:0] copy_b,
  input  logic [WORDS-1:0][WIDTH-1:0] copy_c,
  output logic [WORDS-1:0][WIDTH-1:0] voted,
  output logic [WORDS-1:0]            mismatch
);
  import tmr_cfg_pkg::*;

  for (genvar w = 0; w < WORDS; w++) begin : g_w
    logic [WIDTH-1:0] bit_diff;
    always_comb begin
      for (int b = 0; b < WIDTH; b++) begin
        voted[w][b] = maj3(copy_a[w][b], copy_b[w][b], copy_c[w][b]);
        bit_diff[b] = differ3(copy_a[w][b], copy_b[w][b], copy_c[w][b]);
      end
    end
    assign mismatch[w] = |bit_diff;
  end
endmodule

// File: rtl/tmr_cfg_regfile.sv
module tmr_cfg_regfile #(
  parameter int WORDS = 32,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(WORDS),
  localparam int BW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             burst_clr,
  input  logic             wr_en_a,
  input  logic             wr_en_b,
  input  logic             wr_en_c,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic [WORDS-1:0] err_flags,
  input  logic [2:0]       inj_sel,
  input  logic [AW-1:0]    inj_word,
  input  logic [BW-1:0]    inj_bit
);
  import tmr_cfg_pkg::*;

  logic [2:0] strobe_bus;
  assign strobe_bus = {wr_en_c, wr_en_b, wr_en_a};

  // observation wire for the checker: voted write strobe
  logic wr_vote;
  assign wr_vote = maj3(wr_en_a, wr_en_b, wr_en_c);

  logic [NCOPY-1:0][WORDS-1:0][WIDTH-1:0] planes;

  for (genvar p = 0; p < NCOPY; p++) begin : g_plane
    tmr_plane #(.WORDS(WORDS), .WIDTH(WIDTH)) plane_i (
      .clk       (clk),
      .clr       (burst_clr),
      .strobes   (strobe_bus),
      .addr      (addr),
      .wdata     (wr_data),
      .flip_en   (inj_sel[p]),
      .flip_word (inj_word),
      .flip_bit  (inj_bit),
      .store_q   (planes[p])
    );
  end

  logic [WORDS-1:0][WIDTH-1:0] voted;

  tmr_word_vote #(.WORDS(WORDS), .WIDTH(WIDTH)) vote_i (
    .copy_a   (planes[0]),
    .copy_b   (planes[1]),
    .copy_c   (planes[2]),
    .voted    (voted),
    .mismatch (err_flags)
  );

  assign rd_data = voted[addr];
endmodule

// File: rtl/tmr_cfg_regfile_chk.sv
module tmr_cfg_regfile_chk #(
  parameter int WORDS = 32,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(WORDS),
  localparam int BW = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             burst_clr,
  input logic             wr_en_a,
  input logic             wr_en_b,
  input logic             wr_en_c,
  input logic [AW-1:0]    addr,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] rd_data,
  input logic [WORDS-1:0] err_flags,
  input logic [2:0]       inj_sel,
  input logic [AW-1:0]    inj_word,
  input logic [BW-1:0]    inj_bit,
  input logic             wr_vote
);
  // R1 / R5: the edge after a clear leaves every copy zero
  a_r1_clear_zero: assert property (@(posedge clk) disable iff (burst_clr)
    $fell(burst_clr) |-> (err_flags == '0 && rd_data == '0));

  // R2 / R3: a voted write is visible on the next read of the same address
  a_r2_write_lands: assert property (@(posedge clk) disable iff (burst_clr)
    wr_vote |=> ($stable(addr) -> rd_data == $past(wr_data)));

  // R4: a lone strobe copy changes nothing
  a_r4_lone_strobe: assert property (@(posedge clk) disable iff (burst_clr)
    ($countones({wr_en_a, wr_en_b, wr_en_c}) <= 1 && inj_sel == 3'b000)
      |=> ($stable(addr) -> $stable(rd_data)) && $stable(err_flags));

  // R6: a single-copy flip on a clean array flags exactly that word
  a_r6_single_flag: assert property (@(posedge clk) disable iff (burst_clr)
    ($countones(inj_sel) == 1 && err_flags == '0 && !(wr_vote && addr == inj_word))
      |=> err_flags == (WORDS'(1) << $past(inj_word)));

  // R7: a voted write heals the addressed word
  a_r7_rewrite_heals: assert property (@(posedge clk) disable iff (burst_clr)
    (wr_vote && inj_sel == 3'b000) |=> !err_flags[$past(addr)]);
endmodule

bind tmr_cfg_regfile tmr_cfg_regfile_chk #(.WORDS(WORDS), .WIDTH(WIDTH)) chk_i (.*);

// File: tb/tmr_cfg_regfile_tb_top.sv
module tmr_cfg_regfile_tb_top;
  logic        clk = 1'b0;
  logic        burst_clr = 1'b1;
  logic        wr_en_a = 1'b0, wr_en_b = 1'b0, wr_en_c = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [31:0] err_flags;
  logic [2:0]  inj_sel = '0;
  logic [4:0]  inj_word = '0;
  logic [3:0]  inj_bit = '0;

  int total = 0;
  int bad = 0;
  logic [15:0] model [32];

  always #10 clk = ~clk;

  tmr_cfg_regfile dut_i (.*);

  // fields: strobes[24:22] (c,b,a), addr[21:17], data[16:1], write expected[0]
  localparam logic [24:0] VECS [8] = '{
    {3'b111, 5'd3,  16'hA5A5, 1'b1},
    {3'b011, 5'd3,  16'h1234, 1'b1},
    {3'b101, 5'd7,  16'hBEEF, 1'b1},
    {3'b110, 5'd31, 16'hFFFF, 1'b1},
    {3'b100, 5'd3,  16'h0000, 1'b0},
    {3'b010, 5'd0,  16'hDEAD, 1'b0},
    {3'b001, 5'd31, 16'h0000, 1'b0},
    {3'b111, 5'd0,  16'h8001, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_write(input logic [2:0] s, input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    {wr_en_c, wr_en_b, wr_en_a} = s;
    addr = a;
    wr_data = d;
    @(negedge clk);
    {wr_en_c, wr_en_b, wr_en_a} = 3'b000;
    #1;
  endtask

  task automatic inject(input logic [2:0] sel, input logic [4:0] w, input logic [3:0] b);
    @(negedge clk);
    inj_sel = sel;
    inj_word = w;
    inj_bit = b;
    @(negedge clk);
    inj_sel = 3'b000;
    #1;
  endtask

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    burst_clr = 1'b0;
    #1;
    // R1: state after clear
    addr = 5'd0;  #1 check("R1 word0", 32'(rd_data), 32'h0);
    addr = 5'd31; #1 check("R1 word31", 32'(rd_data), 32'h0);
    check("R1 flags", err_flags, 32'h0);

    // table walk: R2 all strobes, R3 two strobes, R4 one strobe
    for (int k = 0; k < 8; k++) begin
      logic [2:0]  s;
      logic [4:0]  a;
      logic [15:0] d;
      logic        w;
      {s, a, d, w} = VECS[k];
      drive_write(s, a, d);
      if (w) model[a] = d;
      check(w ? "R2/R3 stored" : "R4 unchanged", 32'(rd_data), 32'(model[a]));
      check("R2 flags clean", err_flags, 32'h0);
    end
    // R2: other words untouched
    addr = 5'd7; #1 check("R2 word7 kept", 32'(rd_data), 32'hBEEF);

    // R5: clear beats write
    @(negedge clk);
    burst_clr = 1'b1;
    {wr_en_c, wr_en_b, wr_en_a} = 3'b111;
    addr = 5'd9; wr_data = 16'h5555;
    @(negedge clk);
    burst_clr = 1'b0;
    {wr_en_c, wr_en_b, wr_en_a} = 3'b000;
    #1 check("R5 clear wins", 32'(rd_data), 32'h0);
    addr = 5'd7; #1 check("R1 word7 cleared", 32'(rd_data), 32'h0);

    // R6: one copy flipped
    drive_write(3'b111, 5'd5, 16'h00F0);
    inject(3'b001, 5'd5, 4'd4);
    addr = 5'd5; #1;
    check("R6 read masked", 32'(rd_data), 32'h00F0);
    check("R6 flag word5", err_flags, 32'h0000_0020);

    // R8: second copy of the same bit flipped
    inject(3'b010, 5'd5, 4'd4);
    check("R8 outvoted", 32'(rd_data), 32'h00E0);
    check("R8 flag held", err_flags, 32'h0000_0020);

    // R7: two-strobe rewrite heals
    drive_write(3'b011, 5'd5, 16'h0F0F);
    check("R7 data", 32'(rd_data), 32'h0F0F);
    check("R7 flag cleared", err_flags, 32'h0);

    // R9: combinational read
    drive_write(3'b111, 5'd12, 16'hC0DE);
    addr = 5'd5;  #1 check("R9 addr5", 32'(rd_data), 32'h0F0F);
    addr = 5'd12; #1 check("R9 addr12", 32'(rd_data), 32'hC0DE);

    // R1: a clear also removes an injected disagreement
    inject(3'b100, 5'd20, 4'd15);
    check("R6 flag word20", err_flags, 32'h0010_0000);
    @(negedge clk) burst_clr = 1'b1;
    @(negedge clk) burst_clr = 1'b0;
    #1 check("R1 flags after clear", err_flags, 32'h0);
    check("R1 word12 cleared", 32'(rd_data), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule